// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmit Framer

This block turns bytes into asynchronous serial frames on a single transmit line. A byte enters through a valid/ready stream port. Each frame has a start bit at logic 0, then the data bits sent least significant first, then an optional parity bit, then one or more stop bits at logic 1. Plain control pins set the frame format: word length from five to eight bits, parity on or off, even or odd parity, stick parity and a longer stop period. The block latches these pins when it accepts a byte, so a frame already on the line keeps its format.

Bit timing comes from an external enable pulse at sixteen times the bit rate. One ordinary bit lasts sixteen pulses. When the longer stop period is selected with five-bit words, the second stop bit is a half bit of eight pulses. A break pin forces the serial stream low without stopping the frame timing. A loopback pin holds the external line idle high and sends the serial stream to an internal output.

Back-pressure: `s_ready` is high only while no frame is in progress. A byte transfers on a clock edge where `s_valid` and `s_ready` are both high. From that edge until the last stop period ends, `s_ready` stays low. A source may hold `s_valid` and `s_data` during that time, and nothing is accepted until `s_ready` rises again.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, `txd` and `loop_rx` are 1, `s_ready` is 1 and `busy` is 0. While idle with `line_break` and `loop_en` low, `txd` stays 1.
- R2: A byte is accepted on a clock edge with `s_valid` and `s_ready` both 1. `s_ready` is 0 and `busy` is 1 from that edge until the final stop period ends, then `s_ready` returns to 1. A byte held on the port during a frame is neither taken nor allowed to disturb that frame.
- R3: A frame starts with a start bit of 0 lasting 16 ticks. The data bits follow, least significant first, 16 ticks each. `word_sel` gives the word length: 00 is five bits, 01 six, 10 seven and 11 eight. Data bits above the selected length are ignored.
- R4: When `parity_on` is 1 and `parity_stick` is 0, one parity bit follows the data. With `parity_even` = 1, the data bits and the parity bit together hold an even number of ones. With `parity_even` = 0, they hold an odd number.
- R5: When `parity_on` and `parity_stick` are both 1, the parity bit equals `parity_even`.
- R6: With `stop_long` = 0, the frame ends with one stop bit of 1 lasting 16 ticks. With `stop_long` = 1, the stop period at 1 lasts 32 ticks for six-, seven- and eight-bit words and 24 ticks for five-bit words.
- R7: The frame advances only on clock edges where `bit_tick` is 1. Between ticks, the line and the handshake hold their values.
- R8: The format pins are sampled at acceptance. A change to them during a frame does not alter that frame.
- R9: While `line_break` is 1, the serial stream is 0 (on `txd` when `loop_en` is 0, and on `loop_rx` when `loop_en` is 1). The frame timing and the release of `s_ready` are unchanged.
- R10: While `loop_en` is 1, `txd` is 1 and `loop_rx` carries the serial stream. While `loop_en` is 0, `loop_rx` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | Enable pulse at 16 times the bit rate |
| s_valid | input | 1 | Byte offered |
| s_ready | output | 1 | Framer can accept a byte |
| s_data | input | 8 | Byte to send, least significant bit first |
| word_sel | input | 2 | Word length: 00 five, 01 six, 10 seven, 11 eight bits |
| parity_on | input | 1 | Append a parity bit |
| parity_even | input | 1 | Even parity when 1, odd when 0; stick value in stick mode |
| parity_stick | input | 1 | Send `parity_even` as a constant parity bit |
| stop_long | input | 1 | Longer stop period (2 bits, or 1.5 bits for five-bit words) |
| line_break | input | 1 | Force the serial stream to 0 |
| loop_en | input | 1 | Hold `txd` high and route the stream to `loop_rx` |
| txd | output | 1 | Serial transmit line |
| loop_rx | output | 1 | Internal loopback copy of the serial stream |
| busy | output | 1 | A frame is in progress |

## Verification
Some properties are checked on every cycle by the assertions. A clock edge without a tick must leave the frame state and tick count unchanged. The latched format must stay fixed for as long as a frame runs. An accepted byte must drop `s_ready` on the next edge and start the stream with a 0. An idle line with no break and no loopback must sit at 1. The directed scenarios are the only evidence for the exact bit sequence of each word length, the parity values, the stop durations including the 24-tick case, how break and loopback interact, and that a byte held during a frame does not disturb it.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_START  = 3'd1,
    S_DATA   = 3'd2,
    S_PARITY = 3'd3,
    S_STOP1  = 3'd4,
    S_STOP2  = 3'd5
  } txf_state_t;

  typedef struct packed {
    logic [1:0] wsel;
    logic       par_on;
    logic       par_even;
    logic       par_stick;
    logic       stop_long;
  } txf_fmt_t;
endpackage

// File: rtl/txf_parity.sv
module txf_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        wsel,
  input  logic              par_even,
  input  logic              par_stick,
  output logic              par_bit
);
  localparam int MIN_BITS = DATA_W - 3;

  logic [DATA_W-1:0] mask;
  logic              ones_odd;

  // Build the mask of the bits that belong to the selected word length.
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (i < MIN_BITS) ? 1'b1 : (32'(wsel) >= 32'(i - MIN_BITS + 1));
  end

  assign ones_odd = ^(data & mask);

  always_comb begin
    if (par_stick) par_bit = par_even;
    else if (par_even) par_bit = ones_odd;
    else par_bit = ~ones_odd;
  end
endmodule

// File: rtl/txf_sequencer.sv
module txf_sequencer
  import txf_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  txf_fmt_t          fmt_in,
  input  logic              par_bit,
  output txf_fmt_t          fmt_q,
  output logic [DATA_W-1:0] data_q,
  output logic              frame_bit,
  output logic              busy
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam int IW = $clog2(DATA_W);
  localparam logic [CW-1:0] FULL_LIM = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] HALF_LIM = CW'(OVERSAMPLE / 2 - 1);

  txf_state_t        state;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] shreg;
  logic [CW-1:0]     lim;
  logic [IW-1:0]     last_idx;

  assign in_ready = (state == S_IDLE);
  assign busy     = ~in_ready;
  assign last_idx = IW'(DATA_W - 4) + IW'(fmt_q.wsel);
  assign lim      = (state == S_STOP2 && fmt_q.wsel == 2'b00) ? HALF_LIM : FULL_LIM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      idx    <= '0;
      shreg  <= '0;
      data_q <= '0;
      fmt_q  <= '0;
    end else if (state == S_IDLE) begin
      if (in_valid) begin
        state  <= S_START;
        cnt    <= '0;
        idx    <= '0;
        shreg  <= in_data;
        data_q <= in_data;
        fmt_q  <= fmt_in;
      end
    end else if (tick) begin
      if (cnt != lim) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (state)
          S_START: state <= S_DATA;
          S_DATA: begin
            shreg <= shreg >> 1;
            if (idx == last_idx) state <= fmt_q.par_on ? S_PARITY : S_STOP1;
            else idx <= idx + 1'b1;
          end
          S_PARITY: state <= S_STOP1;
          S_STOP1:  state <= fmt_q.stop_long ? S_STOP2 : S_IDLE;
          default:  state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (state)
      S_START:  frame_bit = 1'b0;
      S_DATA:   frame_bit = shreg[0];
      S_PARITY: frame_bit = par_bit;
      default:  frame_bit = 1'b1;
    endcase
  end

  // R7: no progress without a tick
  p_hold_between_ticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && !tick) |=> ($stable(state) && $stable(cnt)));

  // R8: the latched format is frozen while a frame runs
  p_format_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> $stable(fmt_q));
endmodule

// File: rtl/txf_line.sv
module txf_line (
  input  logic frame_bit,
  input  logic brk,
  input  logic loop_en,
  output logic txd,
  output logic loop_rx
);
  logic stream;

  assign stream  = brk ? 1'b0 : frame_bit;
  assign txd     = loop_en ? 1'b1 : stream;
  assign loop_rx = loop_en ? stream : 1'b1;
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import txf_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  input  logic [1:0] word_sel,
  input  logic       parity_on,
  input  logic       parity_even,
  input  logic       parity_stick,
  input  logic       stop_long,
  input  logic       line_break,
  input  logic       loop_en,
  output logic       txd,
  output logic       loop_rx,
  output logic       busy
);
  localparam int DATA_W = 8;

  txf_fmt_t          fmt_in;
  txf_fmt_t          fmt_q;
  logic [DATA_W-1:0] data_q;
  logic              par_bit;
  logic              frame_bit;

  assign fmt_in = '{wsel: word_sel, par_on: parity_on, par_even: parity_even,
                    par_stick: parity_stick, stop_long: stop_long};

  txf_sequencer #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (bit_tick),
    .in_valid  (s_valid),
    .in_ready  (s_ready),
    .in_data   (s_data),
    .fmt_in    (fmt_in),
    .par_bit   (par_bit),
    .fmt_q     (fmt_q),
    .data_q    (data_q),
    .frame_bit (frame_bit),
    .busy      (busy)
  );

  txf_parity #(.DATA_W(DATA_W)) u_par (
    .data      (data_q),
    .wsel      (fmt_q.wsel),
    .par_even  (fmt_q.par_even),
    .par_stick (fmt_q.par_stick),
    .par_bit   (par_bit)
  );

  txf_line u_line (
    .frame_bit (frame_bit),
    .brk       (line_break),
    .loop_en   (loop_en),
    .txd       (txd),
    .loop_rx   (loop_rx)
  );

  // R2: an accepted byte closes the port on the next edge
  p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  // R3: every frame opens with a low start bit
  p_start_bit_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !frame_bit);

  // R1: an idle, unforced line rests high
  p_idle_line_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !line_break && !loop_en) |-> txd);
endmodule

// File: tb/uart_tx_framer_test.sv
module uart_tx_framer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = '0;
  logic [1:0] word_sel = 2'b11;
  logic       parity_on = 1'b0, parity_even = 1'b0, parity_stick = 1'b0;
  logic       stop_long = 1'b0, line_break = 1'b0, loop_en = 1'b0;
  logic       txd, loop_rx, busy;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  uart_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .word_sel(word_sel), .parity_on(parity_on), .parity_even(parity_even),
    .parity_stick(parity_stick), .stop_long(stop_long), .line_break(line_break),
    .loop_en(loop_en), .txd(txd), .loop_rx(loop_rx), .busy(busy)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0b exp=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Expected serial value after j ticks of a frame with the given format.
  function automatic logic wave_at(int j, logic [7:0] d, int n, logic pe, logic pb);
    int seg = j / 16;
    int k;
    if (seg == 0) return 1'b0;
    if (seg <= n) return d[seg-1];
    k = seg - n - 1;
    if (pe && k == 0) return pb;
    return 1'b1;
  endfunction

  // One frame: checks line, loop output and handshake after every tick and during gaps.
  task automatic run_frame(input string tag, input logic [7:0] d, input logic [1:0] ws,
                           input logic pe, input logic ev, input logic st, input logic sl,
                           input logic lb, input int gap, input int bf, input int bt,
                           input bit chg, input bit hold);
    int   n   = 5 + int'(ws);
    int   len = 16 * (2 + n + int'(pe)) + (sl ? ((n == 5) ? 8 : 16) : 0);
    logic [7:0] m = d & ((8'd1 << n) - 8'd1);
    logic pb  = st ? ev : (ev ? ^m : ~^m);
    @(negedge clk);
    word_sel = ws; parity_on = pe; parity_even = ev; parity_stick = st;
    stop_long = sl; loop_en = lb; s_data = d; s_valid = 1'b1; bit_tick = 1'b0;
    #1 chk({tag, " R2 ready before accept"}, s_ready, 1'b1);
    @(posedge clk);
    @(negedge clk);
    if (hold) s_data = ~d; else s_valid = 1'b0;
    if (chg) begin
      word_sel = ~ws; parity_on = ~pe; parity_even = ~ev; stop_long = ~sl;
    end
    for (int j = 0; j <= len; j++) begin
      logic e, s;
      line_break = (j >= bf && j < bt);
      #1;
      e = wave_at(j, d, n, pe, pb);
      s = line_break ? 1'b0 : e;
      chk({tag, " R3/R4/R5/R6/R9 txd"}, txd, lb ? 1'b1 : s);
      chk({tag, " R10 loop_rx"}, loop_rx, lb ? s : 1'b1);
      chk({tag, " R2 ready"}, s_ready, (j == len));
      chk({tag, " R2 busy"}, busy, (j != len));
      if (j == len) break;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        #1 chk({tag, " R7 hold between ticks"}, lb ? loop_rx : txd, s);
        chk({tag, " R7 ready hold"}, s_ready, 1'b0);
      end
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
    s_valid = 1'b0;
    line_break = 1'b0;
    loop_en = 1'b0;
  endtask

  task automatic test_reset();
    #1;
    chk("R1 reset txd", txd, 1'b1);
    chk("R1 reset loop_rx", loop_rx, 1'b1);
    chk("R1 reset ready", s_ready, 1'b1);
    chk("R1 reset busy", busy, 1'b0);
  endtask

  task automatic test_idle_break();
    @(negedge clk);
    line_break = 1'b1;
    #1 chk("R9 idle break txd", txd, 1'b0);
    chk("R9 break keeps ready", s_ready, 1'b1);
    loop_en = 1'b1;
    #1 chk("R10 loop pin high in break", txd, 1'b1);
    chk("R9 loop stream low in break", loop_rx, 1'b0);
    line_break = 1'b0; loop_en = 1'b0;
    #1 chk("R1 idle line high", txd, 1'b1);
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1 test_reset();
    #20 rst_n = 1'b1;
    test_reset();
    // R3 R6: eight bits, no parity, one stop
    run_frame("8n1", 8'hA5, 2'b11, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3 R4 R6: five bits, upper bits ignored, even parity, 1.5 stop
    run_frame("5e15", 8'hE6, 2'b00, 1, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    // R4 R6 R7: six bits odd parity two stops, gaps between ticks
    run_frame("6o2", 8'h2D, 2'b01, 1, 0, 0, 1, 0, 2, 0, 0, 0, 0);
    // R4: seven bits even parity, held byte during frame
    run_frame("7e1", 8'h71, 2'b10, 1, 1, 0, 0, 0, 0, 0, 0, 0, 1);
    // R5: stick parity high and low
    run_frame("7s1", 8'h00, 2'b10, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    run_frame("8s0", 8'hFF, 2'b11, 1, 0, 1, 1, 0, 1, 0, 0, 0, 0);
    // R8: format pins change mid frame
    run_frame("8chg", 8'h3C, 2'b11, 0, 1, 0, 0, 0, 0, 0, 0, 1, 0);
    run_frame("5chg", 8'h13, 2'b00, 1, 0, 0, 1, 0, 0, 0, 0, 1, 0);
    // R9: break during a frame
    run_frame("brk", 8'h96, 2'b11, 1, 1, 0, 0, 0, 0, 20, 70, 0, 0);
    // R10: loopback, with break in loopback
    run_frame("loop", 8'h5A, 2'b11, 1, 0, 0, 1, 1, 1, 0, 0, 0, 0);
    run_frame("loopbrk", 8'hC3, 2'b01, 0, 0, 0, 0, 1, 0, 40, 60, 0, 0);
    test_idle_break();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule